// File: doc/BRIEF.md
# Rapid Vector Configuration Expander

This block carries out a one-shot reconfiguration of a vector register file's type table. A single scalar operand carries up to three packed groups, each naming an element type and a number of registers. The block walks through the whole register table from index 0 upward and issues one configuration write per clock. Each register gets the type of the group that covers it. Registers past the last covered one get the disabled code. Groups whose type is zero take no registers, so later groups move down to fill the gap.

When the walk ends, the block reports the new maximum vector length (MVL) as its result. In the same cycle it writes that value to the vector length register and pulses a clear for the predicate-count register. The MVL is the number of whole element rows that fit in the physical store: the store size in bytes divided by the sum of count × element bytes over the groups that are used. A small restoring divider computes it while the writes are in progress.

An operand that breaks any rule is rejected after one check cycle. The block then pulses done together with illegal and writes nothing. The controller has six states:
- IDLE waits for start.
- CHECK decodes the operand.
- WRITE issues the per-register writes.
- WAIT holds until the divider is ready.
- DONE reports success.
- FAULT reports rejection.

Its transitions are:
- IDLE→CHECK on start.
- CHECK→FAULT when the operand is illegal.
- CHECK→WRITE when the operand is legal, which also launches the divider.
- WRITE→WAIT after the last index.
- WAIT→DONE when the divider is ready.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `vcfg_expand`

## Requirements
- R1: After reset the block is idle. busy, done, illegal, cfg_we, vl_we and pred_clr are all low.
- R2: Group g (g = 0, 1, 2) holds its 5-bit type in operand bits [10g+4:10g] and its 5-bit count in bits [10g+9:10g+5]. A count of 0 means 32 registers. Any set operand bit at position 30 or above makes the operand illegal.
- R3: A group with type 0 takes no registers. The used groups fill registers in group order, starting at register 0, each taking the next count registers.
- R4: A legal operation issues exactly 32 writes, one per cycle, with cfg_idx rising from 0 to 31. Registers past the last filled one get type 0 (disabled).
- R5: Type bits [2:0] are the width code: 100=8, 101=16, 110=32, 111=64 and 011=128 bits. Bits [4:3] are the class: 01 float, 10 signed, 11 unsigned. A used group is illegal in four cases: class 00, any other width code, a width above ELEN_BYTES (8 bytes by default, so 128 bits is rejected), or an 8-bit float.
- R6: Widths of the used groups must be non-decreasing in group order; a narrower later group is illegal. Equal widths are allowed.
- R7: If the counts of the used groups add up to more than 32, the operand is illegal.
- R8: An illegal operand gives a one-cycle pulse of done with illegal high, two cycles after start. No cfg_we, vl_we or pred_clr is asserted during that operation.
- R9: A legal operation ends with a one-cycle done pulse. In that cycle result and vl_val both equal floor(STORAGE_BYTES / row), where row = Σ count × width bytes. If no group is used, the value is 0. vl_we and pred_clr are high only in that cycle.
- R10: busy rises the cycle after an accepted start and stays high through the done cycle. A start while busy is ignored.
- R11: During every write, cfg_width equals bits [2:0] of cfg_type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| operand | input | XLEN | Packed type/count groups |
| busy | output | 1 | Operation in progress |
| cfg_we | output | 1 | Per-register configuration write strobe |
| cfg_idx | output | $clog2(NREG) | Register being configured |
| cfg_type | output | 5 | Type written to that register |
| cfg_width | output | 3 | Width code written to that register |
| pred_clr | output | 1 | Clear the predicate-register count |
| vl_we | output | 1 | Vector length write strobe |
| vl_val | output | XLEN | New vector length |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Operand rejected (valid with done) |
| result | output | XLEN | MVL returned to the destination register (valid with done) |

## Verification
The checker watches the sequencing rules on every cycle:
- writes start at index 0 and step by one;
- once a disabled type appears, only disabled types follow;
- every legal operation makes exactly 32 writes;
- side effects occur only with a successful done, and done lasts one cycle;
- a rejected operation stays quiet;
- busy follows start.

Only the bench scenarios can show that:
- each register gets the right type for a given packing;
- the legality rules reject exactly the right operands;
- the MVL value is correct;
- a start while busy is ignored.

The bench checks these against its own reference model.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam int PAIRS  = 3;
    localparam int TYPE_W = 5;
    localparam int CNT_W  = 5;
    localparam int PAIR_W = TYPE_W + CNT_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_WRITE,
        S_WAIT,
        S_DONE,
        S_FAULT
    } vcfg_state_e;

    // count in the upper bits, type in the lower bits of each group
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [TYPE_W-1:0] kind;
    } vpair_t;

    function automatic logic [4:0] width_bytes(input logic [2:0] code);
        logic [4:0] b;
        case (code)
            3'b100:  b = 5'd1;
            3'b101:  b = 5'd2;
            3'b110:  b = 5'd4;
            3'b111:  b = 5'd8;
            3'b011:  b = 5'd16;
            default: b = 5'd0;
        endcase
        return b;
    endfunction

    function automatic logic [2:0] width_rank(input logic [2:0] code);
        logic [2:0] r;
        case (code)
            3'b100:  r = 3'd1;
            3'b101:  r = 3'd2;
            3'b110:  r = 3'd3;
            3'b111:  r = 3'd4;
            3'b011:  r = 3'd5;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

    function automatic logic type_legal(input logic [TYPE_W-1:0] t, input int elen_bytes);
        logic [4:0] b;
        logic [1:0] cls;
        b   = width_bytes(t[2:0]);
        cls = t[4:3];
        return (cls != 2'b00) && (b != 5'd0) && (int'(b) <= elen_bytes)
               && !((cls == 2'b01) && (b == 5'd1));
    endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NREG       = 32,
    parameter int ELEN_BYTES = 8,
    parameter int END_W      = 7,
    parameter int ROW_W      = 10
) (
    input  logic [XLEN-1:0]                   op,
    output logic                              legal,
    output logic [PAIRS-1:0][END_W-1:0]       ends,
    output logic [PAIRS-1:0][TYPE_W-1:0]      kinds,
    output logic [ROW_W-1:0]                  row
);
    localparam int USED_W = PAIRS * PAIR_W;
    localparam int SUM_W  = $clog2(PAIRS * NREG * 16 + 1);

    logic             act     [PAIRS];
    logic             tok     [PAIRS];
    logic [2:0]       rank    [PAIRS];
    logic [END_W-1:0] cnt_eff [PAIRS];
    logic [SUM_W-1:0] prod    [PAIRS];
    logic             hi_set;

    assign hi_set = |op[XLEN-1:USED_W];

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        vpair_t pr;
        assign pr         = op[g*PAIR_W +: PAIR_W];
        assign act[g]     = (pr.kind != '0);
        assign tok[g]     = type_legal(pr.kind, ELEN_BYTES);
        assign rank[g]    = width_rank(pr.kind[2:0]);
        assign cnt_eff[g] = (pr.cnt == '0) ? END_W'(NREG) : END_W'(pr.cnt);
        assign prod[g]    = SUM_W'(cnt_eff[g]) * SUM_W'(width_bytes(pr.kind[2:0]));
        assign kinds[g]   = pr.kind;
    end

    always_comb begin
        logic             bad;
        logic [2:0]       last;
        logic [END_W-1:0] tot;
        logic [SUM_W-1:0] sum;
        bad  = hi_set;
        last = '0;
        tot  = '0;
        sum  = '0;
        for (int i = 0; i < PAIRS; i++) begin
            if (act[i]) begin
                if (!tok[i])        bad = 1'b1;
                if (rank[i] < last) bad = 1'b1;
                last = rank[i];
                tot  = tot + cnt_eff[i];
                sum  = sum + prod[i];
            end
            ends[i] = tot;
        end
        if (tot > END_W'(NREG)) bad = 1'b1;
        legal = !bad;
        row   = sum[ROW_W-1:0];
    end

endmodule

// File: rtl/vcfg_div.sv
module vcfg_div #(
    parameter int DIVIDEND = 2048,
    parameter int QW       = 12,
    parameter int DVW      = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [DVW-1:0] divisor,
    output logic           ready,
    output logic [QW-1:0]  quot
);
    localparam int CW = $clog2(QW + 1);

    logic           run;
    logic [CW-1:0]  steps;
    logic [DVW-1:0] rem;
    logic [DVW-1:0] dvs;
    logic [DVW:0]   trial;
    logic [DVW:0]   diff;

    assign trial = {rem, quot[QW-1]};
    assign diff  = trial - {1'b0, dvs};
    assign ready = !run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            steps <= '0;
            rem   <= '0;
            dvs   <= '0;
            quot  <= '0;
        end else if (go) begin
            rem   <= '0;
            dvs   <= divisor;
            steps <= CW'(QW);
            if (divisor == '0) begin
                run  <= 1'b0;
                quot <= '0;
            end else begin
                run  <= 1'b1;
                quot <= QW'(DIVIDEND);
            end
        end else if (run) begin
            if (trial >= {1'b0, dvs}) begin
                rem  <= diff[DVW-1:0];
                quot <= {quot[QW-2:0], 1'b1};
            end else begin
                rem  <= trial[DVW-1:0];
                quot <= {quot[QW-2:0], 1'b0};
            end
            steps <= steps - 1'b1;
            if (steps == CW'(1)) run <= 1'b0;
        end
    end

endmodule

// File: rtl/vcfg_expand.sv
module vcfg_expand
    import vcfg_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter int NREG          = 32,
    parameter int ELEN_BYTES    = 8,
    parameter int STORAGE_BYTES = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [XLEN-1:0]          operand,
    output logic                     busy,
    output logic                     cfg_we,
    output logic [$clog2(NREG)-1:0]  cfg_idx,
    output logic [TYPE_W-1:0]        cfg_type,
    output logic [2:0]               cfg_width,
    output logic                     pred_clr,
    output logic                     vl_we,
    output logic [XLEN-1:0]          vl_val,
    output logic                     done,
    output logic                     illegal,
    output logic [XLEN-1:0]          result
);
    localparam int IDX_W = $clog2(NREG);
    localparam int END_W = $clog2(PAIRS * NREG + 1);
    localparam int ROW_W = $clog2(NREG * 16 + 1);
    localparam int QW    = $clog2(STORAGE_BYTES + 1);

    vcfg_state_e state, state_nx;

    logic [XLEN-1:0]                op_q;
    logic [IDX_W-1:0]               idx;
    logic                           dec_legal;
    logic [PAIRS-1:0][END_W-1:0]    dec_ends;
    logic [PAIRS-1:0][TYPE_W-1:0]   dec_kinds;
    logic [ROW_W-1:0]               dec_row;
    logic                           div_go;
    logic                           div_ready;
    logic [QW-1:0]                  div_q;
    logic [TYPE_W-1:0]              sel_type;
    logic                           last_idx;

    vcfg_decode #(
        .XLEN(XLEN), .NREG(NREG), .ELEN_BYTES(ELEN_BYTES),
        .END_W(END_W), .ROW_W(ROW_W)
    ) u_dec (
        .op    (op_q),
        .legal (dec_legal),
        .ends  (dec_ends),
        .kinds (dec_kinds),
        .row   (dec_row)
    );

    vcfg_div #(
        .DIVIDEND(STORAGE_BYTES), .QW(QW), .DVW(ROW_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .divisor (dec_row),
        .ready   (div_ready),
        .quot    (div_q)
    );

    assign div_go   = (state == S_CHECK) && dec_legal;
    assign last_idx = (idx == IDX_W'(NREG - 1));

    // group that covers the current register; skipped groups have empty spans
    always_comb begin
        logic found;
        found    = 1'b0;
        sel_type = '0;
        for (int i = 0; i < PAIRS; i++) begin
            if (!found && (END_W'(idx) < dec_ends[i])) begin
                sel_type = dec_kinds[i];
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_CHECK;
            S_CHECK: state_nx = dec_legal ? S_WRITE : S_FAULT;
            S_WRITE: if (last_idx) state_nx = S_WAIT;
            S_WAIT:  if (div_ready) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            S_FAULT: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            idx  <= '0;
        end else begin
            if (state == S_IDLE && start) op_q <= operand;
            if (state == S_CHECK)         idx  <= '0;
            else if (state == S_WRITE)    idx  <= idx + 1'b1;
        end
    end

    always_comb begin
        cfg_we    = 1'b0;
        cfg_type  = '0;
        cfg_width = '0;
        pred_clr  = 1'b0;
        vl_we     = 1'b0;
        vl_val    = '0;
        done      = 1'b0;
        illegal   = 1'b0;
        result    = '0;
        unique case (state)
            S_WRITE: begin
                cfg_we    = 1'b1;
                cfg_type  = sel_type;
                cfg_width = sel_type[2:0];
            end
            S_DONE: begin
                done     = 1'b1;
                vl_we    = 1'b1;
                pred_clr = 1'b1;
                vl_val   = XLEN'(div_q);
                result   = XLEN'(div_q);
            end
            S_FAULT: begin
                done    = 1'b1;
                illegal = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign cfg_idx = idx;

endmodule

// File: rtl/vcfg_expand_chk.sv
module vcfg_expand_chk #(
    parameter int XLEN = 64,
    parameter int NREG = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    cfg_we,
    input logic [$clog2(NREG)-1:0] cfg_idx,
    input logic [4:0]              cfg_type,
    input logic                    pred_clr,
    input logic                    vl_we,
    input logic [XLEN-1:0]         vl_val,
    input logic                    done,
    input logic                    illegal,
    input logic [XLEN-1:0]         result
);
    localparam int WC_W = $clog2(NREG + 2);

    logic [WC_W-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)     wr_cnt <= '0;
        else if (done)  wr_cnt <= '0;
        else if (cfg_we) wr_cnt <= wr_cnt + 1'b1;
    end

    p_first_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !$past(cfg_we)) |-> (cfg_idx == '0));

    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && $past(cfg_we)) |-> (cfg_idx == $past(cfg_idx) + 1'b1));

    p_tail_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_type == '0) |=> (!cfg_we || cfg_type == '0));

    p_all_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |-> (wr_cnt == WC_W'(NREG)));

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (wr_cnt == '0 && !vl_we && !pred_clr));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_side_effects_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_we || pred_clr) |-> (done && !illegal && vl_we && pred_clr && vl_val == result));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_busy_through_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || cfg_we) |-> busy);

endmodule

bind vcfg_expand vcfg_expand_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_type (cfg_type),
    .pred_clr (pred_clr),
    .vl_we    (vl_we),
    .vl_val   (vl_val),
    .done     (done),
    .illegal  (illegal),
    .result   (result)
);

// File: tb/sim_vcfg_expand.sv
module sim_vcfg_expand;

    localparam int XLEN    = 64;
    localparam int NREG    = 32;
    localparam int STORAGE = 2048;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [XLEN-1:0] operand = '0;
    logic            busy, cfg_we, pred_clr, vl_we, done, illegal;
    logic [4:0]      cfg_idx;
    logic [4:0]      cfg_type;
    logic [2:0]      cfg_width;
    logic [XLEN-1:0] vl_val, result;

    always #2 clk = ~clk;

    vcfg_expand u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .busy(busy), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_type(cfg_type),
        .cfg_width(cfg_width), .pred_clr(pred_clr), .vl_we(vl_we), .vl_val(vl_val),
        .done(done), .illegal(illegal), .result(result)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference results
    bit         exp_ill;
    logic [4:0] exp_typ [NREG];
    longint     exp_mvl;

    // observations
    int         wr_n;
    bit         order_bad, width_bad, seen_done, side_seen;
    bit         got_ill, got_vl_we, got_pred;
    logic [4:0] got_typ [NREG];
    longint     got_res, got_vl;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic int ref_bytes(input logic [2:0] c);
        case (c)
            3'b100: return 1;
            3'b101: return 2;
            3'b110: return 4;
            3'b111: return 8;
            3'b011: return 16;
            default: return 0;
        endcase
    endfunction

    task automatic ref_model(input logic [XLEN-1:0] op);
        int last, tot, row;
        exp_ill = (op[XLEN-1:30] != '0);   // R2
        last = 0; tot = 0; row = 0;
        for (int r = 0; r < NREG; r++) exp_typ[r] = 5'd0;
        for (int p = 0; p < 3; p++) begin
            logic [4:0] t, c;
            int n, b;
            t = op[10*p +: 5];
            c = op[10*p+5 +: 5];
            n = (c == 0) ? 32 : int'(c);
            if (t != 0) begin
                b = ref_bytes(t[2:0]);
                if (t[4:3] == 2'b00 || b == 0 || b > 8 || (t[4:3] == 2'b01 && b == 1)) exp_ill = 1;
                if (b < last) exp_ill = 1;
                last = b;
                for (int k = 0; k < n; k++) if (tot + k < NREG) exp_typ[tot + k] = t;
                tot += n;
                row += n * b;
            end
        end
        if (tot > NREG) exp_ill = 1;
        exp_mvl = (row == 0) ? 0 : STORAGE / row;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_we) begin
                if (int'(cfg_idx) != wr_n) order_bad = 1;
                if (cfg_width != cfg_type[2:0]) width_bad = 1;
                got_typ[cfg_idx] = cfg_type;
                wr_n++;
            end
            if (vl_we || pred_clr) side_seen = 1;
            if (done) begin
                seen_done = 1;
                got_ill   = illegal;
                got_res   = longint'(result);
                got_vl    = longint'(vl_val);
                got_vl_we = vl_we;
                got_pred  = pred_clr;
            end
        end
    end

    task automatic run_op(input logic [XLEN-1:0] op, input bit poke, input logic [XLEN-1:0] op2);
        int cyc;
        int bad_regs;
        ref_model(op);
        @(negedge clk);
        wr_n = 0; order_bad = 0; width_bad = 0; seen_done = 0; side_seen = 0;
        for (int r = 0; r < NREG; r++) got_typ[r] = 5'h1f;
        operand = op;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            operand = op2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!seen_done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        check(seen_done, "R9", "done seen", seen_done, 1);
        check(got_ill == exp_ill, "R5/R6/R7 R2", "illegal flag", got_ill, exp_ill);
        if (exp_ill) begin
            check(wr_n == 0, "R8", "writes on reject", wr_n, 0);
            check(!side_seen, "R8", "side effect on reject", side_seen, 0);
        end else begin
            bad_regs = 0;
            for (int r = 0; r < NREG; r++) begin
                if (got_typ[r] !== exp_typ[r]) begin
                    bad_regs++;
                    if (bad_regs == 1)
                        check(0, "R3 R4", $sformatf("type of reg %0d", r), got_typ[r], exp_typ[r]);
                end
            end
            if (bad_regs == 0) check(1, "R3 R4", "types", 0, 0);
            check(wr_n == NREG && !order_bad, "R4", "write count/order", wr_n, NREG);
            check(!width_bad, "R11", "width matches type", width_bad, 0);
            check(got_res == exp_mvl, "R9", "result MVL", got_res, exp_mvl);
            check(got_vl == exp_mvl && got_vl_we, "R9", "vl write", got_vl, exp_mvl);
            check(got_pred, "R9", "predicate clear", got_pred, 1);
        end
        @(negedge clk);
        if (poke) check(!busy, "R10", "start while busy ignored", busy, 0);
    endtask

    function automatic logic [4:0] code_of(input int rk);
        case (rk)
            1: return 5'd4;
            2: return 5'd5;
            3: return 5'd6;
            4: return 5'd7;
            default: return 5'd3;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] mk(input logic [4:0] t0, input logic [4:0] c0,
                                           input logic [4:0] t1, input logic [4:0] c1,
                                           input logic [4:0] t2, input logic [4:0] c2);
        logic [XLEN-1:0] v;
        v = '0;
        v[4:0] = t0;   v[9:5] = c0;
        v[14:10] = t1; v[19:15] = c1;
        v[24:20] = t2; v[29:25] = c2;
        return v;
    endfunction

    initial begin
        #(4 * 190000);
        check(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !illegal && !cfg_we && !vl_we && !pred_clr,
              "R1", "idle after reset", {busy, done, cfg_we, vl_we}, 0);

        // directed corner cases
        run_op('0, 0, '0);                                          // R3 all skipped, MVL 0
        run_op(mk(5'b10100, 5'd0, 0, 0, 0, 0), 0, '0);              // R2 count 0 means 32
        run_op(mk(5'b10110, 5'd4, 0, 0, 0, 0), 0, '0);              // R9 row 16 -> 128
        run_op(mk(0, 5'd7, 5'b11101, 5'd3, 5'b01111, 5'd2), 0, '0); // R3 skipped first
        run_op(mk(5'b10101, 5'd2, 0, 5'd9, 5'b01110, 5'd5), 0, '0); // R3 skipped middle
        run_op(mk(5'b10110, 5'd16, 5'b01110, 5'd16, 0, 0), 0, '0);  // R7 exactly 32
        run_op(mk(5'b10110, 5'd16, 5'b01110, 5'd17, 0, 0), 0, '0);  // R7 33 illegal
        run_op(mk(5'b10110, 5'd0, 5'b10100, 5'd0, 5'b10100, 5'd0), 0, '0); // R7 96
        run_op(mk(5'b11110, 5'd2, 5'b10101, 5'd2, 0, 0), 0, '0);    // R6 decreasing
        run_op(mk(5'b11110, 5'd2, 5'b10110, 5'd2, 5'b01110, 5'd3), 0, '0); // R6 equal ok
        run_op(mk(5'b01100, 5'd1, 0, 0, 0, 0), 0, '0);              // R5 float 8
        run_op(mk(5'b10011, 5'd1, 0, 0, 0, 0), 0, '0);              // R5 128 too wide
        run_op(mk(5'b00110, 5'd1, 0, 0, 0, 0), 0, '0);              // R5 class 00
        run_op(mk(5'b10010, 5'd1, 0, 0, 0, 0), 0, '0);              // R5 bad code
        run_op(mk(5'b10100, 5'd1, 0, 0, 0, 0) | (64'd1 << 40), 0, '0); // R2 high bit
        run_op(mk(5'b10111, 5'd3, 0, 0, 0, 0), 1,
               mk(5'b10100, 5'd1, 0, 0, 0, 0));                     // R10 poke while busy

        // constrained random
        for (int n = 0; n < 300; n++) begin
            int rk [3];
            logic [4:0] t [3];
            logic [4:0] c [3];
            for (int p = 0; p < 3; p++)
                rk[p] = ($urandom_range(0, 19) == 0) ? 5 : $urandom_range(1, 4);
            if ($urandom_range(0, 4) != 0) begin
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 2 - a; b++)
                        if (rk[b] > rk[b+1]) begin
                            int tmp;
                            tmp = rk[b]; rk[b] = rk[b+1]; rk[b+1] = tmp;
                        end
            end
            for (int p = 0; p < 3; p++) begin
                logic [1:0] cls;
                cls = ($urandom_range(0, 9) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
                t[p] = ($urandom_range(0, 4) == 0) ? 5'd0 : {cls, code_of(rk[p])[2:0]};
                c[p] = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 12));
            end
            run_op(mk(t[0], c[0], t[1], c[1], t[2], c[2]), 0, '0);
        end

        finish_run();
    end

endmodule